// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This block gathers the live status flags of a UART channel into one byte of interrupt status, gates that byte with a mask written by software, and drives a single active-high, level-sensitive interrupt request. The transmit bit tracks the transmitter's ready flag. The receive bit tracks either "at least one byte waiting" or "receive FIFO full", as chosen by a mode bit. A sticky break flag is set by a break-detected pulse and is cleared only by a dedicated clear pulse from the command decoder.

Software reaches the unit through a small register port. A write at the interrupt offset loads the mask. A read at the same offset returns the status byte. Reads of any other offset return zero, and writes to any other offset have no effect. The interrupt line is registered, so it follows the masked status one clock later and produces no edges of its own.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Status bit 0 (transmit) equals `tx_ready` in the same cycle, with no register delay.
- R2: When `rx_irq_on_full` is 0, status bit 1 (receive) equals `rx_ready` in the same cycle, and `fifo_full` is ignored.
- R3: When `rx_irq_on_full` is 1, status bit 1 equals `fifo_full` in the same cycle, and `rx_ready` is ignored.
- R4: A cycle with `break_pulse` high sets status bit 2 (break) from the next cycle on. It stays set for as long as no clear arrives.
- R5: A cycle with `break_clr` high and `break_pulse` low clears status bit 2 from the next cycle on. If both are high in the same cycle, the bit is set.
- R6: A write (`reg_wr` high) with `reg_addr` equal to 0x14 loads `reg_wdata` into the mask from the next cycle on. A write to any other offset leaves the mask unchanged.
- R7: A read with `reg_addr` equal to 0x14 returns the status byte on `reg_rdata` in the same cycle. Any other offset returns 0.
- R8: `irq_out` is a register. In each cycle it shows whether the bitwise AND of status and mask was nonzero in the previous cycle.
- R9: While `rst_n` is low at a clock edge, the mask, the break flag and `irq_out` are cleared to 0.
- R10: Status bits 7 down to 3 always read 0. Bit 7 is kept for a change-of-state source that is not present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_ready | input | 1 | Transmitter can take a byte |
| rx_ready | input | 1 | At least one received byte is waiting |
| fifo_full | input | 1 | Receive FIFO is full |
| rx_irq_on_full | input | 1 | Receive interrupt source select: 1 = FIFO full, 0 = byte waiting |
| break_pulse | input | 1 | One-cycle pulse when a break is detected |
| break_clr | input | 1 | One-cycle pulse from the command decoder that clears the break flag |
| reg_addr | input | 6 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| irq_out | output | 1 | Registered active-high interrupt request |

## Verification
The transmit and receive status bits and the read data are combinational, so the bench samples them a short delay after driving the inputs, within the same cycle. The break flag and the mask take effect at the first clock edge after their strobe, so they are checked after one edge. `irq_out` adds one more register, so after a mask write the bench expects it to stay low for the first edge and to follow the new mask only after the second. All sampling and driving happen mid-period, away from the active edge.

// File: rtl/uart_irq_pkg.sv
// Shared constants for the UART interrupt unit.
// Assumes a byte-wide status/mask register; bit positions are decoded by software.
package uart_irq_pkg;
    localparam int REG_W   = 8;
    localparam int ADDR_W  = 6;
    localparam logic [ADDR_W-1:0] IRQ_OFS = 6'h14;
    localparam int BIT_TX  = 0;
    localparam int BIT_RX  = 1;
    localparam int BIT_BRK = 2;
    localparam int BIT_COS = 7;
    localparam int LIVE_BITS = BIT_BRK + 1;
endpackage

// File: rtl/uirq_status.sv
// Builds the interrupt status byte.
// Bits 0 and 1 come straight from live status inputs; bit 2 is a sticky break flag.
// Assumes break_set and break_clr are single-cycle strobes; set wins over clear.
module uirq_status #(
    parameter int REG_W   = uart_irq_pkg::REG_W,
    parameter int BIT_TX  = uart_irq_pkg::BIT_TX,
    parameter int BIT_RX  = uart_irq_pkg::BIT_RX,
    parameter int BIT_BRK = uart_irq_pkg::BIT_BRK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_ready,
    input  logic             rx_ready,
    input  logic             fifo_full,
    input  logic             rx_sel_full,
    input  logic             break_set,
    input  logic             break_clr,
    output logic [REG_W-1:0] status,
    output logic             brk_flag
);
    localparam int FIRST_RSVD = BIT_BRK + 1;

    logic rx_src;

    // Pick the receive interrupt source from the mode bit.
    always_comb begin
        rx_src = rx_sel_full ? fifo_full : rx_ready;
    end

    // Sticky break flag: set on a break, cleared only by the clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_flag <= 1'b0;
        end else if (break_set) begin
            brk_flag <= 1'b1;
        end else if (break_clr) begin
            brk_flag <= 1'b0;
        end
    end

    // Place the live and sticky bits at their positions.
    always_comb begin
        status[BIT_TX]  = tx_ready;
        status[BIT_RX]  = rx_src;
        status[BIT_BRK] = brk_flag;
    end

    // Reserved bits, including the change-of-state position, tie low.
    generate
        for (genvar g = FIRST_RSVD; g < REG_W; g++) begin : g_rsvd
            assign status[g] = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/uirq_mask.sv
// Software-written interrupt mask register.
// Loads on a write strobe at the mask offset; all other offsets are ignored.
module uirq_mask #(
    parameter int REG_W  = uart_irq_pkg::REG_W,
    parameter int ADDR_W = uart_irq_pkg::ADDR_W,
    parameter logic [ADDR_W-1:0] MASK_OFS = uart_irq_pkg::IRQ_OFS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  mask
);
    logic hit;

    // Decode a write aimed at the mask.
    always_comb begin
        hit = reg_wr && (reg_addr == MASK_OFS);
    end

    // Hold the mask; load it on a decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (hit) begin
            mask <= reg_wdata;
        end
    end
endmodule

// File: rtl/uirq_line.sv
// Registered interrupt request: high when any status bit meets a set mask bit.
// Assumes a level-sensitive consumer; no edge generation.
module uirq_line #(
    parameter int REG_W = uart_irq_pkg::REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] status,
    input  logic [REG_W-1:0] mask,
    output logic             irq
);
    logic [REG_W-1:0] hits;

    // Per-bit gating of status by mask.
    generate
        for (genvar g = 0; g < REG_W; g++) begin : g_hit
            assign hits[g] = status[g] & mask[g];
        end
    endgenerate

    // Register the OR of all gated bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= |hits;
        end
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
// Top of the UART interrupt unit: status build, mask register, interrupt line
// and the register read mux. Reads are combinational and side-effect free.
module uart_irq_ctrl #(
    parameter int REG_W  = uart_irq_pkg::REG_W,
    parameter int ADDR_W = uart_irq_pkg::ADDR_W,
    parameter logic [ADDR_W-1:0] IRQ_OFS = uart_irq_pkg::IRQ_OFS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_ready,
    input  logic              rx_ready,
    input  logic              fifo_full,
    input  logic              rx_irq_on_full,
    input  logic              break_pulse,
    input  logic              break_clr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq_out
);
    logic [REG_W-1:0] status_w;
    logic [REG_W-1:0] mask_q;
    logic             brk_q;

    uirq_status #(.REG_W(REG_W)) i_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_ready   (tx_ready),
        .rx_ready   (rx_ready),
        .fifo_full  (fifo_full),
        .rx_sel_full(rx_irq_on_full),
        .break_set  (break_pulse),
        .break_clr  (break_clr),
        .status     (status_w),
        .brk_flag   (brk_q)
    );

    uirq_mask #(.REG_W(REG_W), .ADDR_W(ADDR_W), .MASK_OFS(IRQ_OFS)) i_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .mask     (mask_q)
    );

    uirq_line #(.REG_W(REG_W)) i_line (
        .clk   (clk),
        .rst_n (rst_n),
        .status(status_w),
        .mask  (mask_q),
        .irq   (irq_out)
    );

    // Read mux: status at the interrupt offset, zero elsewhere.
    always_comb begin
        reg_rdata = (reg_addr == IRQ_OFS) ? status_w : '0;
    end
endmodule

// File: rtl/uart_irq_chk.sv
// Property checker for uart_irq_ctrl, attached by bind.
module uart_irq_chk #(
    parameter int REG_W  = uart_irq_pkg::REG_W,
    parameter int ADDR_W = uart_irq_pkg::ADDR_W,
    parameter logic [ADDR_W-1:0] IRQ_OFS = uart_irq_pkg::IRQ_OFS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_ready,
    input logic              rx_ready,
    input logic              fifo_full,
    input logic              rx_irq_on_full,
    input logic              break_pulse,
    input logic              break_clr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              irq_out,
    input logic [REG_W-1:0]  status_w,
    input logic [REG_W-1:0]  mask_q,
    input logic              brk_q
);
    AST_TX_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == IRQ_OFS) |-> (reg_rdata[0] == tx_ready)); // R1
    AST_RX_READY_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_addr == IRQ_OFS) && !rx_irq_on_full) |-> (reg_rdata[1] == rx_ready)); // R2
    AST_RX_FULL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_addr == IRQ_OFS) && rx_irq_on_full) |-> (reg_rdata[1] == fifo_full)); // R3
    AST_BRK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        break_pulse |=> brk_q); // R4
    AST_BRK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_q && !break_clr) |=> brk_q); // R4
    AST_BRK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (break_clr && !break_pulse) |=> !brk_q); // R5
    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && (reg_addr == IRQ_OFS)) |=> $stable(mask_q)); // R6
    AST_READ_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != IRQ_OFS) |-> (reg_rdata == '0)); // R7
    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_w & mask_q) != '0) |=> irq_out); // R8
    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_w & mask_q) == '0) |=> !irq_out); // R8
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> ((mask_q == '0) && !brk_q && !irq_out)); // R9
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status_w[REG_W-1:3] == '0)); // R10
endmodule

bind uart_irq_ctrl uart_irq_chk #(.REG_W(REG_W), .ADDR_W(ADDR_W), .IRQ_OFS(IRQ_OFS)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_ready      (tx_ready),
    .rx_ready      (rx_ready),
    .fifo_full     (fifo_full),
    .rx_irq_on_full(rx_irq_on_full),
    .break_pulse   (break_pulse),
    .break_clr     (break_clr),
    .reg_addr      (reg_addr),
    .reg_wr        (reg_wr),
    .reg_rdata     (reg_rdata),
    .irq_out       (irq_out),
    .status_w      (status_w),
    .mask_q        (mask_q),
    .brk_q         (brk_q)
);

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_ready = 1'b0, rx_ready = 1'b0, fifo_full = 1'b0, rx_irq_on_full = 1'b0;
    logic       break_pulse = 1'b0, break_clr = 1'b0;
    logic [5:0] reg_addr = 6'h00;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_out;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    localparam logic [5:0] OFS = 6'h14;
    // Vector: {tx, rx, full, sel, exp_rx_bit, exp_tx_bit}
    localparam logic [5:0] VEC [8] = '{
        6'b0000_00, 6'b1000_01, 6'b0100_10, 6'b0010_00,
        6'b0110_10, 6'b0011_10, 6'b0101_00, 6'b1111_11
    };

    always #10 clk = ~clk;   // 50 MHz

    uart_irq_ctrl i_uart_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .tx_ready(tx_ready), .rx_ready(rx_ready),
        .fifo_full(fifo_full), .rx_irq_on_full(rx_irq_on_full),
        .break_pulse(break_pulse), .break_clr(break_clr), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance to 5 ns after the next rising edge.
    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic write_mask(input logic [5:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0; reg_addr = OFS;
        #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        tick(); tick();
        reg_addr = OFS; #1;
        check("R9 status after reset", reg_rdata, 8'h00);
        check("R9 irq after reset", {7'b0, irq_out}, 8'h00);
        rst_n = 1'b1;
        tick();

        // R1 R2 R3: vector table, combinational status bits
        for (int i = 0; i < 8; i++) begin
            {tx_ready, rx_ready, fifo_full, rx_irq_on_full} = VEC[i][5:2];
            #1;
            check("R1 R2 R3 live bits", reg_rdata, {6'b0, VEC[i][1:0]});
            tick();
        end
        {tx_ready, rx_ready, fifo_full, rx_irq_on_full} = 4'b0000;

        // R4: break sets sticky bit 2 one cycle later
        break_pulse = 1'b1; #1;
        check("R4 break not yet set", reg_rdata, 8'h00);
        tick(); break_pulse = 1'b0; #1;
        check("R4 break set", reg_rdata, 8'h04);
        tick(); tick();
        check("R4 break held", reg_rdata, 8'h04);

        // R5: clear, and set wins over clear
        break_clr = 1'b1; tick(); break_clr = 1'b0; #1;
        check("R5 break cleared", reg_rdata, 8'h00);
        break_clr = 1'b1; break_pulse = 1'b1; tick();
        break_clr = 1'b0; break_pulse = 1'b0; #1;
        check("R5 set wins", reg_rdata, 8'h04);

        // R7: other offsets read zero
        reg_addr = 6'h10; #1;
        check("R7 other offset", reg_rdata, 8'h00);
        reg_addr = OFS; #1;

        // R10: reserved bits zero with every source active
        tx_ready = 1'b1; rx_ready = 1'b1; fifo_full = 1'b1; #1;
        check("R10 reserved bits", reg_rdata & 8'hF8, 8'h00);
        tx_ready = 1'b0; rx_ready = 1'b0; fifo_full = 1'b0;
        break_clr = 1'b1; tick(); break_clr = 1'b0; tick();

        // R6: write to another offset does not load the mask
        tx_ready = 1'b1;
        write_mask(6'h08, 8'hFF);
        tick();
        check("R6 ignored write", {7'b0, irq_out}, 8'h00);

        // R6 R8: mask write, irq follows one cycle after mask
        write_mask(OFS, 8'h01);
        check("R8 irq not yet", {7'b0, irq_out}, 8'h00);
        tick();
        check("R8 irq raised", {7'b0, irq_out}, 8'h01);
        tx_ready = 1'b0; #1;
        check("R8 irq still registered", {7'b0, irq_out}, 8'h01);
        tick();
        check("R8 irq dropped", {7'b0, irq_out}, 8'h00);

        // R8: masked break source drives irq
        write_mask(OFS, 8'h04);
        break_pulse = 1'b1; tick(); break_pulse = 1'b0;
        tick();
        check("R8 break irq", {7'b0, irq_out}, 8'h01);

        // R3 with mask: fifo_full source via rx bit
        break_clr = 1'b1; tick(); break_clr = 1'b0;
        write_mask(OFS, 8'h02);
        rx_irq_on_full = 1'b1; rx_ready = 1'b1; tick(); tick();
        check("R3 rx_ready ignored when full selected", {7'b0, irq_out}, 8'h00);
        fifo_full = 1'b1; tick(); tick();
        check("R3 full raises irq", {7'b0, irq_out}, 8'h01);

        // R9: reset mid-run clears mask, break and irq
        break_pulse = 1'b1; tick(); break_pulse = 1'b0;
        rst_n = 1'b0; tick(); rst_n = 1'b1; #1;
        check("R9 irq after reset", {7'b0, irq_out}, 8'h00);
        rx_irq_on_full = 1'b0; rx_ready = 1'b0; fifo_full = 1'b0; #1;
        check("R9 break after reset", reg_rdata, 8'h00);
        tx_ready = 1'b1; tick(); tick();
        check("R9 mask after reset", {7'b0, irq_out}, 8'h00);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule